// File: doc/BRIEF.md
# Configuration Start-Up Sequencer

This block steps a programmable-logic device from power-on to user mode. Once reset is released it clears configuration memory, pulling the open-drain init line low for a fixed number of cycles. When it lets go of the line, it waits until the line actually reads high, because another agent may still be holding it low. It then waits for the loader to report that loading has finished. At that point it pulses a global set/reset for one cycle and runs an eight-phase start-up count.

During the start-up count it raises three sticky releases in turn: done, then the global output-enable (three-state) release, then the global write-enable release. Each one rises at a phase set by a parameter. Two mode pins change this timing. The first holds the count at a chosen phase until a clock manager reports lock. The second makes the two global releases wait for an external wired-done level, so that several devices can start together. Pulling the active-low program input low at any moment drops every release and restarts the sequence from memory clearing.

All logic runs on the start-up clock, and the reset is synchronous and active low.

Top module: `cfg_startup_seq`

## Requirements
- R1: After reset, `init_pull_o` (1 = pull the init line low) is high for exactly CLEAR_CYCLES cycles and then goes low. `gsr_o`, `done_o`, `tri_release_o` and `we_release_o` are 0 in reset.
- R2: After clearing, the block stays in its wait state while `init_sense_i` reads 0. `gsr_o` cannot occur until `init_sense_i` has been seen high.
- R3: `prog_n` = 0 puts the block back into clearing in the next cycle. Clearing then lasts CLEAR_CYCLES cycles, counted from the first cycle in which `prog_n` is 1.
- R4: The block enters loading in the cycle after it sees `init_sense_i` = 1. If `load_done_i` is 1 in that loading cycle, `gsr_o` is high in the cycle after.
- R5: `gsr_o` is high for exactly one cycle per sequence.
- R6: The start-up phase is 0 in the cycle after `gsr_o`, and it increases by one per cycle unless it is stalled. `done_o` rises in the cycle after phase DONE_PHASE (default 4). This is DONE_PHASE+2 cycles after `gsr_o` when there are no stalls.
- R7: With the default phases and no external gating, `tri_release_o` rises one cycle after `done_o`.
- R8: `we_release_o` rises one cycle after `tri_release_o`.
- R9: With `sync_mode_i` = 1, the phase count holds at TRI_PHASE while `wired_done_i` = 0, and `tri_release_o` rises in the cycle after `wired_done_i` is first seen at 1 in that phase. With `sync_mode_i` = 0, `wired_done_i` has no effect.
- R10: With `lock_wait_i` = 1, the phase count holds at LOCK_PHASE (default 2) while `lock_i` = 0. With `lock_wait_i` = 0, `lock_i` has no effect.
- R11: `done_o`, `tri_release_o` and `we_release_o` are 0 during clearing and loading. Once raised, each stays high until the next `prog_n` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Start-up clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| prog_n | input | 1 | Active-low restart request |
| init_sense_i | input | 1 | Sensed level of the open-drain init line |
| load_done_i | input | 1 | Configuration data loading finished |
| lock_i | input | 1 | Clock manager locked |
| wired_done_i | input | 1 | External wired-done level |
| sync_mode_i | input | 1 | 1 = global releases wait for wired done |
| lock_wait_i | input | 1 | 1 = stall at LOCK_PHASE until lock |
| init_pull_o | output | 1 | 1 = drive the init line low |
| gsr_o | output | 1 | Global set/reset pulse |
| done_o | output | 1 | Done release |
| tri_release_o | output | 1 | Global three-state release |
| we_release_o | output | 1 | Global write-enable release |

## Verification
The assertions check on every cycle that the set/reset pulse lasts one cycle and that a restart clears the releases. They also check that each global release follows the one before it, that a sync-mode release is preceded by wired done, and that the phase count holds at the lock phase and in the wait state when it should. The exact cycle distances cannot be shown by assertions alone: the length of clearing, the delay from init release to set/reset, and the done-to-release offsets after lock or wired-done stalls of various lengths. The bench shows these by sweeping hold-off, lock and wired-done delays across both mode pins.

// File: rtl/cfg_startup_pkg.sv
// Package: shared state encoding for the start-up sequencer.
// Assumes: one clock domain (the start-up clock).
package cfg_startup_pkg;

    typedef enum logic [2:0] {
        SEQ_CLEAR = 3'd0,
        SEQ_WAIT  = 3'd1,
        SEQ_LOAD  = 3'd2,
        SEQ_GSR   = 3'd3,
        SEQ_RUN   = 3'd4,
        SEQ_USER  = 3'd5
    } seq_state_t;

endpackage

// File: rtl/cfg_clear_timer.sv
// Module: cfg_clear_timer
// Counts the memory-clearing interval. The count restarts whenever a restart
// is requested or the sequencer is outside the clearing state.
// Assumes: CLEAR_CYCLES >= 1.
module cfg_clear_timer #(
    parameter int CLEAR_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic active_i,
    output logic last_o
);
    localparam int CNT_W = $clog2(CLEAR_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(CLEAR_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    // Purpose: advance the clearing count while the block is clearing
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i || !active_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST_VAL) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last_o = active_i && !restart_i && (cnt_q == LAST_VAL);

    // R1
    clear_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_VAL);
endmodule

// File: rtl/cfg_phase_ctr.sv
// Module: cfg_phase_ctr
// Start-up phase counter. Holds at zero while the sequencer is not in the
// start-up state, then steps once per cycle up to the last phase. It holds at
// LOCK_PHASE while a lock wait is pending, and at any phase where a release
// stage reports a stall.
// Assumes: LOCK_PHASE lies below the last phase.
module cfg_phase_ctr #(
    parameter int PHASE_W    = 3,
    parameter int LOCK_PHASE = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic               lock_wait_i,
    input  logic               lock_i,
    input  logic               ext_stall_i,
    output logic [PHASE_W-1:0] phase_o,
    output logic               last_o
);
    localparam logic [PHASE_W-1:0] MAX_PH  = {PHASE_W{1'b1}};
    localparam logic [PHASE_W-1:0] LOCK_PH = PHASE_W'(LOCK_PHASE);

    logic [PHASE_W-1:0] phase_q;
    logic               lock_hold;
    logic               hold;

    // Purpose: decide whether the count may move on this cycle
    always_comb begin
        lock_hold = lock_wait_i && !lock_i && (phase_q == LOCK_PH);
        hold      = lock_hold || ext_stall_i || (phase_q == MAX_PH);
    end

    // Purpose: phase register
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            phase_q <= '0;
        end else if (!hold) begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign phase_o = phase_q;
    assign last_o  = run_i && (phase_q == MAX_PH);

    // R10
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && lock_wait_i && !lock_i && phase_q == LOCK_PH)
        |=> (phase_q == LOCK_PH || !run_i));

    // R6
    phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && $past(run_i) && phase_q != $past(phase_q))
        |-> (phase_q == $past(phase_q) + 1'b1));
endmodule

// File: rtl/cfg_release_bank.sv
// Module: cfg_release_bank
// A bank of sticky release flags. Flag i sets when the phase count equals its
// phase and its gate is open. It stays set until a restart. While a flag
// waits on a closed gate at its phase, the bank asks the counter to stall.
// Assumes: the phase list is ascending.
module cfg_release_bank #(
    parameter int                         NUM_REL = 3,
    parameter int                         PHASE_W = 3,
    parameter logic [NUM_REL*PHASE_W-1:0] PHASES  = {3'd6, 3'd5, 3'd4}
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart_i,
    input  logic               run_i,
    input  logic [PHASE_W-1:0] phase_i,
    input  logic [NUM_REL-1:0] gate_i,
    output logic [NUM_REL-1:0] rel_o,
    output logic               stall_o
);
    logic [NUM_REL-1:0] rel_q;
    logic [NUM_REL-1:0] wait_v;

    for (genvar i = 0; i < NUM_REL; i++) begin : g_rel
        localparam logic [PHASE_W-1:0] MY_PH = PHASES[i*PHASE_W +: PHASE_W];
        logic at_phase;

        assign at_phase  = run_i && (phase_i == MY_PH);
        assign wait_v[i] = at_phase && !gate_i[i] && !rel_q[i];

        // Purpose: sticky release flag for stage i
        always_ff @(posedge clk) begin
            if (!rst_n || restart_i) begin
                rel_q[i] <= 1'b0;
            end else if (at_phase && gate_i[i]) begin
                rel_q[i] <= 1'b1;
            end
        end

        // R11
        sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rel_q[i] && !restart_i) |=> rel_q[i]);
    end

    for (genvar j = 1; j < NUM_REL; j++) begin : g_order
        // R8
        order_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rel_q[j]) |-> $past(rel_q[j-1]));
    end

    assign rel_o   = rel_q;
    assign stall_o = |wait_v;
endmodule

// File: rtl/cfg_startup_seq.sv
// Module: cfg_startup_seq (top)
// Configuration start-up sequencer: clear, wait for the init line, load,
// set/reset pulse, then a phased start-up that raises done, the three-state
// release and the write-enable release.
// Assumes: all inputs are synchronous to clk; the bench or board models the
// open-drain init line (init_sense_i low whenever init_pull_o is high).
module cfg_startup_seq
    import cfg_startup_pkg::*;
#(
    parameter int CLEAR_CYCLES = 16,
    parameter int PHASE_W      = 3,
    parameter int LOCK_PHASE   = 2,
    parameter int DONE_PHASE   = 4,
    parameter int TRI_PHASE    = 5,
    parameter int WE_PHASE     = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic prog_n,
    input  logic init_sense_i,
    input  logic load_done_i,
    input  logic lock_i,
    input  logic wired_done_i,
    input  logic sync_mode_i,
    input  logic lock_wait_i,
    output logic init_pull_o,
    output logic gsr_o,
    output logic done_o,
    output logic tri_release_o,
    output logic we_release_o
);
    localparam int NUM_REL = 3;
    localparam logic [NUM_REL*PHASE_W-1:0] REL_PHASES =
        {PHASE_W'(WE_PHASE), PHASE_W'(TRI_PHASE), PHASE_W'(DONE_PHASE)};

    seq_state_t          state_q;
    logic                restart;
    logic                clear_last;
    logic                run;
    logic [PHASE_W-1:0]  phase;
    logic                phase_last;
    logic                rel_stall;
    logic [NUM_REL-1:0]  gates;
    logic [NUM_REL-1:0]  rels;
    logic                ext_ok;

    assign restart = !prog_n;
    assign run     = (state_q == SEQ_RUN);

    // Purpose: top-level sequence state
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            state_q <= SEQ_CLEAR;
        end else begin
            case (state_q)
                SEQ_CLEAR: if (clear_last)   state_q <= SEQ_WAIT;
                SEQ_WAIT:  if (init_sense_i) state_q <= SEQ_LOAD;
                SEQ_LOAD:  if (load_done_i)  state_q <= SEQ_GSR;
                SEQ_GSR:                     state_q <= SEQ_RUN;
                SEQ_RUN:   if (phase_last)   state_q <= SEQ_USER;
                default:                     state_q <= SEQ_USER;
            endcase
        end
    end

    // Purpose: gate for each release stage (done is never gated)
    always_comb begin
        ext_ok = !sync_mode_i || wired_done_i;
        gates  = {ext_ok, ext_ok, 1'b1};
    end

    cfg_clear_timer #(
        .CLEAR_CYCLES(CLEAR_CYCLES)
    ) u_clear (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart_i(restart),
        .active_i (state_q == SEQ_CLEAR),
        .last_o   (clear_last)
    );

    cfg_phase_ctr #(
        .PHASE_W   (PHASE_W),
        .LOCK_PHASE(LOCK_PHASE)
    ) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run),
        .lock_wait_i(lock_wait_i),
        .lock_i     (lock_i),
        .ext_stall_i(rel_stall),
        .phase_o    (phase),
        .last_o     (phase_last)
    );

    cfg_release_bank #(
        .NUM_REL(NUM_REL),
        .PHASE_W(PHASE_W),
        .PHASES (REL_PHASES)
    ) u_rel (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart_i(restart),
        .run_i    (run),
        .phase_i  (phase),
        .gate_i   (gates),
        .rel_o    (rels),
        .stall_o  (rel_stall)
    );

    assign init_pull_o   = (state_q == SEQ_CLEAR);
    assign gsr_o         = (state_q == SEQ_GSR);
    assign done_o        = rels[0];
    assign tri_release_o = rels[1];
    assign we_release_o  = rels[2];

    // R5
    gsr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gsr_o |=> !gsr_o);

    // R3
    restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_n |=> (init_pull_o && !done_o && !tri_release_o && !we_release_o));

    // R2
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_WAIT && !init_sense_i && prog_n) |=> (state_q == SEQ_WAIT));

    // R9
    sync_wired_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_mode_i && $past(sync_mode_i) && $rose(tri_release_o)) |-> $past(wired_done_i));

    // R7
    tri_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tri_release_o) |-> $past(done_o));

    // R11
    quiet_in_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_LOAD || state_q == SEQ_WAIT) |-> !(done_o || tri_release_o || we_release_o));
endmodule

// File: tb/cfg_startup_seq_test.sv
// Bench: sweeps init hold-off, lock delay, wired-done delay and both mode pins
// on a short clearing interval. Expected rise cycles are computed from the
// requirements. Sampling and driving both happen at the falling edge, in one
// process.
module cfg_startup_seq_test;
    localparam int CC = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic prog_n = 1'b1;
    logic hold_low = 1'b1;
    logic load_done = 1'b1;
    logic lock = 1'b0;
    logic wired = 1'b0;
    logic sync_mode = 1'b0;
    logic lock_wait = 1'b0;
    logic init_pull, gsr, done, tri_rel, we_rel;
    logic init_sense;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    assign init_sense = !init_pull && !hold_low;

    cfg_startup_seq #(.CLEAR_CYCLES(CC)) uut (
        .clk(clk), .rst_n(rst_n), .prog_n(prog_n),
        .init_sense_i(init_sense), .load_done_i(load_done),
        .lock_i(lock), .wired_done_i(wired),
        .sync_mode_i(sync_mode), .lock_wait_i(lock_wait),
        .init_pull_o(init_pull), .gsr_o(gsr), .done_o(done),
        .tri_release_o(tri_rel), .we_release_o(we_rel)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One full sequence started by a restart pulse.
    task automatic run_case(input int h, input int lw, input int d,
                            input int sy, input int wd);
        int g, dexp, texp, wexp, len;
        int t_init, t_gsr, t_done, t_tri, t_we, gsr_n;
        g    = CC + h + 2;
        dexp = g + 6 + (lw != 0 ? d : 0);
        texp = (sy != 0) ? dexp + wd + 1 : dexp + 1;
        wexp = texp + 1;
        len  = wexp + 4;
        t_init = -1; t_gsr = -1; t_done = -1; t_tri = -1; t_we = -1; gsr_n = 0;
        lock_wait = lw[0];
        sync_mode = sy[0];
        @(negedge clk);
        prog_n = 1'b0; hold_low = 1'b1; lock = 1'b0; wired = 1'b0;
        @(negedge clk);
        @(negedge clk);
        // R3 / R11: restart drops every release and re-enters clearing
        chk("R3 init pull on restart", int'(init_pull), 1);
        chk("R11 releases cleared", int'(done | tri_rel | we_rel), 0);
        for (int t = 0; t <= len; t++) begin
            if (t > 0) @(negedge clk);
            if (!init_pull && t_init < 0) t_init = t;
            if (gsr) begin
                gsr_n++;
                if (t_gsr < 0) t_gsr = t;
            end
            if (done && t_done < 0) t_done = t;
            if (tri_rel && t_tri < 0) t_tri = t;
            if (we_rel && t_we < 0) t_we = t;
            prog_n   = 1'b1;
            hold_low = (t < CC + h);
            lock     = (t >= g + 3 + d);
            wired    = (sy != 0) ? (t >= dexp + wd) : 1'b0;
        end
        chk("R1/R3 clear length", t_init, CC);
        chk("R2/R4 gsr cycle", t_gsr, g);
        chk("R5 gsr width", gsr_n, 1);
        chk("R6/R10 done cycle", t_done, dexp);
        chk("R7/R9 tri cycle", t_tri, texp);
        chk("R8 we cycle", t_we, wexp);
        chk("R11 releases held", int'(done & tri_rel & we_rel), 1);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 reset init pull", int'(init_pull), 1);
        chk("R1 reset outputs", int'(gsr | done | tri_rel | we_rel), 0);
        rst_n = 1'b1;
        for (int h = 0; h < 3; h++)
            for (int lw = 0; lw < 2; lw++)
                for (int d = 0; d <= 3; d += 3)
                    for (int sy = 0; sy < 2; sy++)
                        for (int wd = 0; wd <= 2; wd += 2)
                            run_case(h * 2, lw, d, sy, wd);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule